// File: doc/BRIEF.md
# Frame-Sync Serial Master

This block is a master for a synchronous serial link that marks each word with a one-clock frame-sync pulse rather than a held select line. Words of 4 to 16 bits are queued in an eight-entry transmit FIFO. The block divides the system clock down to a serial clock. It announces each word with a frame-sync pulse and then shifts the word out MSB first. At the same time it shifts in the word that the remote device returns, and it places that word in an eight-entry receive FIFO.

While no word is pending, the serial clock and frame sync rest low and the transmit data driver is released. The pad then sees `dx_en` low and floats the line. If another word is already queued when a frame reaches its last bit, the next frame-sync pulse is sent during that last bit. Frames then follow one another with no gap.

Top module: `fsync_serial_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sck`, `fs` and `dx_en` are all low.
- R2: With `enable` high and the transmit FIFO not empty, a frame starts. `fs` rises together with a rising edge of `sck` and stays high for exactly one serial clock period.
- R3: One serial clock period lasts 2*`sck_half` system clock cycles. The high half and the low half each last `sck_half` cycles.
- R4: The word at the head of the transmit FIFO is driven on `dx_out` MSB first. Each bit changes on a rising edge of `sck`, and the first bit appears on the rising edge after the one that raised `fs`. `dx_en` is high while the data bits are sent.
- R5: `dr` is sampled on each falling edge of `sck` during the data bits, MSB first.
- R6: A frame carries `word_len_m1`+1 bits for `word_len_m1` values 3 to 15. Values 0, 1 and 2 give 4-bit frames.
- R7: A received word is placed in the receive FIFO at the first `sck` rising-edge time after its LSB was sampled. It is right-justified and its unused upper bits are zero.
- R8: If the transmit FIFO still holds a word when the LSB period of a frame begins, `fs` is raised for that LSB period and the next frame follows directly. The `fs` rising edges are then exactly (frame bits)*2*`sck_half` cycles apart.
- R9: The transmit FIFO holds 8 words. `tx_full` is high when it holds 8, and a write while full is ignored.
- R10: The receive FIFO holds 8 words and shows its oldest word on `rx_data`. `rx_rd` removes that word. `rx_full` and `rx_empty` report its fill level.
- R11: A word that completes while the receive FIFO is full is dropped and sets `rx_overrun`. The flag stays high until reset.
- R12: While `enable` is low, no frame starts, even if words are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new frames to start |
| sck_half | input | 8 | Serial clock half period in system cycles (at least 1) |
| word_len_m1 | input | 4 | Frame length minus one |
| tx_wr | input | 1 | Write strobe for the transmit FIFO |
| tx_data | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit FIFO holds 8 words |
| tx_empty | output | 1 | Transmit FIFO holds no word |
| rx_rd | input | 1 | Removes the oldest received word |
| rx_data | output | 16 | Oldest received word |
| rx_full | output | 1 | Receive FIFO holds 8 words |
| rx_empty | output | 1 | Receive FIFO holds no word |
| rx_overrun | output | 1 | Sticky flag: a received word was dropped |
| sck | output | 1 | Serial clock |
| fs | output | 1 | Frame-sync pulse |
| dx_out | output | 1 | Transmit data |
| dx_en | output | 1 | Output enable for the transmit data pad |
| dr | input | 1 | Receive data |

## Verification
The bench builds the block with its default parameters: 16-bit words, FIFOs 8 deep and an 8-bit half-period input. With a depth of 8, both a full transmit FIFO and a receive overrun can be reached with a handful of short 4-bit frames. The vector table varies `sck_half` from 1 to 4, so the narrowest divider and the uneven multi-cycle ones are both timed. The frame lengths cover 16 bits, several middle lengths and the clamped short setting.

// File: rtl/fsync_serial_master.sv
module fsync_serial_master #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int DIVW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [DIVW-1:0]      sck_half,
  input  logic [$clog2(W)-1:0] word_len_m1,
  input  logic                 tx_wr,
  input  logic [W-1:0]         tx_data,
  output logic                 tx_full,
  output logic                 tx_empty,
  input  logic                 rx_rd,
  output logic [W-1:0]         rx_data,
  output logic                 rx_full,
  output logic                 rx_empty,
  output logic                 rx_overrun,
  output logic                 sck,
  output logic                 fs,
  output logic                 dx_out,
  output logic                 dx_en,
  input  logic                 dr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(W + 1);
  localparam int MW = $clog2(W);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // transmit queue
  logic [W-1:0]  tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_push, tx_pop;

  assign tx_full  = tx_cnt == CW'(DEPTH);
  assign tx_empty = tx_cnt == '0;
  assign tx_push  = tx_wr && !tx_full;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= tx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= ptr_inc(tx_wp);
      if (tx_pop)  tx_rp <= ptr_inc(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  // receive queue
  logic [W-1:0]  rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_push, rx_accept, rx_pop;
  logic [W-1:0]  rxsh;

  assign rx_full   = rx_cnt == CW'(DEPTH);
  assign rx_empty  = rx_cnt == '0;
  assign rx_accept = rx_push && !rx_full;
  assign rx_pop    = rx_rd && !rx_empty;
  assign rx_data   = rx_mem[rx_rp];

  always_ff @(posedge clk)
    if (rx_accept) rx_mem[rx_wp] <= rxsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp      <= '0;
      rx_rp      <= '0;
      rx_cnt     <= '0;
      rx_overrun <= 1'b0;
    end else begin
      if (rx_accept) rx_wp <= ptr_inc(rx_wp);
      if (rx_pop)    rx_rp <= ptr_inc(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_accept) - CW'(rx_pop);
      if (rx_push && rx_full) rx_overrun <= 1'b1;
    end
  end

  // frame engine
  logic            busy;
  logic [DIVW-1:0] cnt;
  logic [LW-1:0]   pos, nbits;
  logic [W-1:0]    txsh;
  logic            tick, rise, fall, last, start, load;

  assign nbits = (word_len_m1 < MW'(3)) ? LW'(4) : LW'(word_len_m1) + LW'(1);
  assign tick  = busy && (cnt == sck_half - DIVW'(1));
  assign rise  = tick && !sck;
  assign fall  = tick && sck;
  assign last  = pos == nbits;
  assign start = enable && !busy && !tx_empty;
  assign load  = rise && ((pos == '0) || (last && fs));
  assign tx_pop  = load;
  assign rx_push = rise && last;
  assign dx_out  = txsh[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      pos   <= '0;
      sck   <= 1'b0;
      fs    <= 1'b0;
      dx_en <= 1'b0;
      txsh  <= '0;
      rxsh  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      pos  <= '0;
      sck  <= 1'b1;
      fs   <= 1'b1;
    end else if (busy) begin
      cnt <= tick ? '0 : cnt + DIVW'(1);
      if (fall) begin
        sck <= 1'b0;
        if (pos != '0) rxsh <= {rxsh[W-2:0], dr};
      end
      if (rise) begin
        if (load) begin
          pos   <= LW'(1);
          sck   <= 1'b1;
          fs    <= 1'b0;
          dx_en <= 1'b1;
          txsh  <= tx_mem[tx_rp] << (LW'(W) - nbits);
          rxsh  <= '0;
        end else if (last) begin
          busy  <= 1'b0;
          dx_en <= 1'b0;
        end else begin
          pos  <= pos + LW'(1);
          sck  <= 1'b1;
          txsh <= txsh << 1;
          fs   <= (pos + LW'(1) == nbits) && enable && !tx_empty;
        end
      end
    end
  end
endmodule

// File: rtl/fsync_serial_master_chk.sv
module fsync_serial_master_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          sck,
  input logic          fs,
  input logic          dx_en,
  input logic          tx_full,
  input logic [CW-1:0] tx_cnt,
  input logic          rx_full,
  input logic          rx_empty,
  input logic          rx_overrun
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !fs && !dx_en));
  // R2
  fs_with_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs) |-> $rose(sck));
  // R4
  data_after_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_en) |-> $past(fs));
  // R9
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  // R9
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !busy) |=> tx_full);
  // R10
  rx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_full && rx_empty));
  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_overrun);
endmodule

bind fsync_serial_master fsync_serial_master_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .fs(fs), .dx_en(dx_en),
  .tx_full(tx_full), .tx_cnt(tx_cnt), .rx_full(rx_full), .rx_empty(rx_empty),
  .rx_overrun(rx_overrun)
);

// File: tb/test_fsync_serial_master.sv
module test_fsync_serial_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [7:0]  sck_half = 8'd2;
  logic [3:0]  word_len_m1 = 4'd7;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, dr = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_full, tx_empty, rx_full, rx_empty, rx_overrun;
  logic [15:0] rx_data;
  logic        sck, fs, dx_out, dx_en;

  fsync_serial_master i_fsync_serial_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sck_half(sck_half),
    .word_len_m1(word_len_m1), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
    .sck(sck), .fs(fs), .dx_out(dx_out), .dx_en(dx_en), .dr(dr));

  always #(CLK_PERIOD/2) clk = ~clk;

  // half, len_m1, tx word, slave word
  localparam logic [43:0] VEC [6] = '{
    {8'd2, 4'd7,  16'h00A5, 16'h00C3},
    {8'd1, 4'd15, 16'hBEEF, 16'h1234},
    {8'd3, 4'd3,  16'h0009, 16'h0006},
    {8'd2, 4'd11, 16'h0ABC, 16'h0F0F},
    {8'd4, 4'd0,  16'h0005, 16'hFFFF},
    {8'd1, 4'd4,  16'h0013, 16'h001E}
  };

  int errors = 0, checks = 0, cyc = 0;
  logic [15:0] q_tx [32];
  logic [15:0] q_dr [32];
  int wi = 0, fi = 0, cur_n = 8, frames_seen = 0;
  int fs_rise_cyc = 0, last_fs_gap = 0, fs_width = 0;
  int last_rise = 0, rise_gap = 0, hi_w = 0;

  function automatic logic [15:0] msk(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  function automatic int eff_n(input logic [3:0] lm);
    return (lm < 4'd3) ? 4 : int'(lm) + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // slave model and line monitor
  initial begin
    logic ps = 1'b0, pf = 1'b0, armed = 1'b0;
    int bit_left = 0, cap_left = 0;
    logic [15:0] cap = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        ps = 1'b0; pf = 1'b0; armed = 1'b0; bit_left = 0; cap_left = 0;
      end else begin
        if (fs && !pf) begin
          last_fs_gap = cyc - fs_rise_cyc;
          fs_rise_cyc = cyc;
        end
        if (!fs && pf) fs_width = cyc - fs_rise_cyc;
        if (sck && !ps) begin
          rise_gap  = cyc - last_rise;
          last_rise = cyc;
          if (armed) begin
            bit_left = cur_n; cap_left = cur_n; cap = '0;
            fi++; frames_seen++;
          end
          if (bit_left > 0) begin
            dr = q_dr[fi-1][bit_left-1];
            bit_left--;
          end
          armed = fs;
        end
        if (!sck && ps) begin
          hi_w = cyc - last_rise;
          if (cap_left > 0) begin
            cap = {cap[14:0], dx_out & dx_en};
            cap_left--;
            if (cap_left == 0)
              // R4 R6 transmitted bits MSB first
              check(cap == (q_tx[fi-1] & msk(cur_n)), "R4", cap, q_tx[fi-1] & msk(cur_n));
          end
        end
        ps = sck; pf = fs;
      end
    end
  end

  task automatic push_word(input logic [15:0] t, input logic [15:0] d, input bit store);
    if (store) begin q_tx[wi] = t; q_dr[wi] = d; wi++; end
    @(negedge clk); tx_wr = 1'b1; tx_data = t;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (!(tx_empty && !sck && !fs && !dx_en) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int fcount;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!sck && !fs && !dx_en, "R1", {sck, fs, dx_en}, 0);
    check(tx_empty && rx_empty && !rx_overrun && !tx_full && !rx_full, "R10",
          {tx_empty, rx_empty, rx_overrun}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      logic [15:0] t, d;
      int n, h;
      h = int'(VEC[i][43:36]);
      t = VEC[i][31:16];
      d = VEC[i][15:0];
      enable = 1'b0;
      sck_half = VEC[i][43:36];
      word_len_m1 = VEC[i][35:32];
      n = eff_n(VEC[i][35:32]);
      cur_n = n;
      fcount = frames_seen;
      push_word(t, d, 1'b1);
      enable = 1'b1;
      wait_idle();
      // R6 one frame of the clamped or programmed length
      check(frames_seen == fcount + 1, "R6", frames_seen - fcount, 1);
      // R2 one period of frame sync
      check(fs_width == 2*h, "R2", fs_width, 2*h);
      // R3 period and high half
      check(rise_gap == 2*h && hi_w == h, "R3", rise_gap, 2*h);
      // R1 lines idle after a single frame
      check(!sck && !fs && !dx_en, "R1", {sck, fs, dx_en}, 0);
      // R5 R7 right-justified received word
      check(!rx_empty && rx_data == (d & msk(n)), "R7", rx_data, d & msk(n));
      pop_rx();
    end

    // R8 back-to-back frames
    enable = 1'b0; sck_half = 8'd2; word_len_m1 = 4'd7; cur_n = 8;
    fcount = frames_seen;
    push_word(16'h0081, 16'h0055, 1'b1);
    push_word(16'h00F0, 16'h00AA, 1'b1);
    push_word(16'h003C, 16'h0099, 1'b1);
    enable = 1'b1;
    wait_idle();
    check(frames_seen == fcount + 3, "R8", frames_seen - fcount, 3);
    check(last_fs_gap == 8*4, "R8", last_fs_gap, 32);
    check(rx_data == 16'h0055, "R5", rx_data, 16'h0055); pop_rx();
    check(rx_data == 16'h00AA, "R5", rx_data, 16'h00AA); pop_rx();
    check(rx_data == 16'h0099, "R5", rx_data, 16'h0099); pop_rx();
    check(rx_empty, "R10", rx_empty, 1);

    // R12 R9 fill with enable low
    enable = 1'b0; sck_half = 8'd1; word_len_m1 = 4'd3; cur_n = 4;
    fcount = frames_seen;
    for (int k = 1; k <= 9; k++)
      push_word(16'(k), 16'(~k & 4'hF), k <= 8);
    check(tx_full, "R9", tx_full, 1);
    repeat (20) @(negedge clk);
    check(frames_seen == fcount && !fs, "R12", frames_seen - fcount, 0);
    enable = 1'b1;
    wait_idle();
    check(frames_seen == fcount + 8, "R9", frames_seen - fcount, 8);
    check(rx_full && !rx_overrun, "R10", {rx_full, rx_overrun}, 2'b10);
    // R11 overrun
    push_word(16'h000A, 16'h0005, 1'b1);
    wait_idle();
    check(rx_overrun, "R11", rx_overrun, 1);
    for (int k = 1; k <= 8; k++) begin
      check(rx_data == 16'(~k & 4'hF), "R10", rx_data, ~k & 4'hF);
      pop_rx();
    end
    check(rx_empty && rx_overrun, "R11", {rx_empty, rx_overrun}, 2'b11);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!rx_overrun && rx_empty && tx_empty, "R11", rx_overrun, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule